// File: doc/BRIEF.md
# Keypad Controller Command Bank

This block is the register side of a keypad and port-expander controller that sits behind a serial byte transport. The transport layer sends a transaction-start strobe with a direction flag. Written bytes then arrive one per valid pulse, and read bytes are pulled one per request. In a write transaction the first byte selects a command and the bytes after it are that command's parameters. In a read transaction the selected command chooses what each returned byte holds.

The bank holds the setup the rest of the controller consumes: a configuration byte, a scan clock setting, the active-time and debounce values, the keypad geometry, three 16-bit port setup words, a script-memory write port and start/stop strobes for three pulse engines. Every parameter is range-checked. A bad value is still stored, but it sets a bit in a sticky error register and an error flag in the interrupt status byte. The active-low interrupt line is asserted whenever the status byte is nonzero. After a command takes its last parameter, the command register parks on 0xFF, so a stray extra byte is reported as a bad parameter and is not taken as data.

Top module: `kpd_cmd_bank`

## Requirements
- R1: After reset, reading configuration returns 0x00, clock returns 0x0A, keypad size returns 0x33 and status returns 0x10. Debounce is 3, active time is 125 and irq_n is low.
- R2: A transaction start clears the byte counter. In a write, byte 0 loads the command and later bytes are parameters 0, 1, 2. Reading command 0x80 returns 0x00, then 0x04, then 0x00.
- R3: Any newly set error bit also sets status bit 3. After a command's final parameter, one further parameter byte sets error bit 0 (bad parameter).
- R4: Command 0x90 stores the keypad size, which is read back by 0x91. The size is valid only when its low nibble is in 3..12 and its high nibble is in 3..8. Otherwise error bit 0 is set, and the value is still stored.
- R5: Command 0x8F stores debounce, and a value of 0 sets error bit 0. Command 0x93 stores the clock, and low bits 01 or 10 set error bit 0. Reading 0x94 returns the stored clock with bits [1:0] forced to 10.
- R6: Command 0x83 with parameter 0xAA restores all reset values, clears the error register and clears the port words. Any other parameter sets error bit 0 and changes nothing else.
- R7: Commands 0x84, 0x85 and 0x86 load the pull, direction and mask words, low byte first and then high byte. Commands 0x87 and 0x88 read back direction and mask, low byte first.
- R8: Reading 0x82 returns the status byte and then clears it, unless bit 4 is set. irq_n is low exactly while the status byte is nonzero.
- R9: Writing 0x81 stores the configuration, clears status and pulses key_clr for one cycle. Reading 0x92 returns the configuration's low nibble.
- R10: A write or read of an opcode outside the command set sets error bit 1, and such a read returns 0x00.
- R11: Command 0x95 takes an address byte, then a high data byte, then a low data byte. The address byte is rejected as a bad parameter if its bits [1:0] are 0 or its bits [7:2] exceed 59. After the low byte, scr_wr pulses with the address and the 16-bit word.
- R12: Commands 0x96 and 0x97 pulse eng_go and eng_halt on engine (value[1:0] − 1). A zero value[1:0] is a bad parameter, and so is value[7:2] above 59 for 0x96. 0x96 also presents value[7:2] on eng_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Start of a transaction, one cycle |
| xfer_is_write | input | 1 | Direction sampled with xfer_start, 1 = write |
| wr_valid | input | 1 | Written byte present |
| wr_data | input | 8 | Written byte |
| rd_req | input | 1 | Host consumes one read byte this cycle |
| rd_data | output | 8 | Byte returned for the current command and counter |
| key_byte | input | 8 | Head byte of the external key event queue |
| key_clr | output | 1 | One-cycle pulse that empties the key queue |
| irq_n | output | 1 | Interrupt, low while status is nonzero |
| act_time | output | 8 | Active-time setting |
| debounce | output | 8 | Debounce setting |
| keypad_size | output | 8 | Keypad geometry, rows and columns as nibbles |
| gpio_pull | output | GPIO_W | Port pull selection |
| gpio_dir | output | GPIO_W | Port direction |
| gpio_mask | output | GPIO_W | Port state/mask word |
| scr_wr | output | 1 | Script word write strobe |
| scr_addr | output | 8 | Script write address byte |
| scr_word | output | 16 | Script data word |
| eng_go | output | N_ENG | One-hot engine start pulse |
| eng_halt | output | N_ENG | One-hot engine stop pulse |
| eng_addr | output | 6 | Start address given to the last started engine |

## Verification
The embedded properties check a set of rules on every cycle. A new error bit must always bring the status error flag with it. A status read must drop the interrupt unless the not-initialised flag is set, and that flag must survive a status read. A completed single-parameter command must park the command register. A transaction start must zero the counter. The engine strobes must stay one-hot. What only the scenarios can show is the data itself: range limits at both ends of each field, the values stored despite errors, the byte order of 16-bit loads and reads, soft reset with a good and a bad key, and the read-back formatting of clock and configuration.

// File: rtl/kcb_pkg.sv
package kcb_pkg;
  // command opcodes
  localparam logic [7:0] OP_ID       = 8'h80;
  localparam logic [7:0] OP_CFG_WR   = 8'h81;
  localparam logic [7:0] OP_STAT_RD  = 8'h82;
  localparam logic [7:0] OP_SOFT_RST = 8'h83;
  localparam logic [7:0] OP_PULL_WR  = 8'h84;
  localparam logic [7:0] OP_DIR_WR   = 8'h85;
  localparam logic [7:0] OP_MASK_WR  = 8'h86;
  localparam logic [7:0] OP_DIR_RD   = 8'h87;
  localparam logic [7:0] OP_MASK_RD  = 8'h88;
  localparam logic [7:0] OP_KEY_POP  = 8'h89;
  localparam logic [7:0] OP_KEY_PEEK = 8'h8A;
  localparam logic [7:0] OP_ACT_WR   = 8'h8B;
  localparam logic [7:0] OP_ERR_RD   = 8'h8C;
  localparam logic [7:0] OP_ROT_RD   = 8'h8E;
  localparam logic [7:0] OP_DEB_WR   = 8'h8F;
  localparam logic [7:0] OP_SIZE_WR  = 8'h90;
  localparam logic [7:0] OP_SIZE_RD  = 8'h91;
  localparam logic [7:0] OP_CFG_RD   = 8'h92;
  localparam logic [7:0] OP_CLK_WR   = 8'h93;
  localparam logic [7:0] OP_CLK_RD   = 8'h94;
  localparam logic [7:0] OP_SCR_WR   = 8'h95;
  localparam logic [7:0] OP_ENG_GO   = 8'h96;
  localparam logic [7:0] OP_ENG_HALT = 8'h97;
  localparam logic [7:0] OP_PARKED   = 8'hFF;

  // error and status bit positions
  localparam int ERRB_PARAM = 0;
  localparam int ERRB_CMD   = 1;
  localparam int STB_ERR    = 3;
  localparam int STB_NOINIT = 4;

  // reset values
  localparam logic [7:0] RST_CFG  = 8'h80;
  localparam logic [7:0] RST_STAT = 8'h10;
  localparam logic [7:0] RST_ACT  = 8'd125;
  localparam logic [7:0] RST_DEB  = 8'd3;
  localparam logic [7:0] RST_SIZE = 8'h33;
  localparam logic [7:0] RST_CLK  = 8'h08;
  localparam logic [7:0] RST_KEY  = 8'hAA;
  localparam logic [15:0] ID_WORD = 16'h0400;
endpackage

// File: rtl/kcb_wr_check.sv
module kcb_wr_check
  import kcb_pkg::*;
#(
  parameter int CNT_W      = 2,
  parameter int KDIM_MIN   = 3,
  parameter int KROW_MAX   = 12,
  parameter int KCOL_MAX   = 8,
  parameter int SCRIPT_MAX = 59
) (
  input  logic [7:0]       op,
  input  logic [CNT_W-1:0] idx,
  input  logic [7:0]       val,
  output logic             known,
  output logic             bad,
  output logic             done
);
  logic sel_zero;
  logic addr_high;

  assign sel_zero  = (val[1:0] == 2'b00);
  assign addr_high = (val[7:2] > 6'(SCRIPT_MAX));

  always_comb begin
    known = 1'b1;
    bad   = 1'b0;
    done  = 1'b0;
    unique case (op)
      OP_CFG_WR, OP_ACT_WR: done = 1'b1;
      OP_SOFT_RST: begin
        done = 1'b1;
        bad  = (val != RST_KEY);
      end
      OP_PULL_WR, OP_DIR_WR, OP_MASK_WR: done = (idx != '0);
      OP_DEB_WR: begin
        done = 1'b1;
        bad  = (val == 8'h00);
      end
      OP_SIZE_WR: begin
        done = 1'b1;
        bad  = (val[3:0] < 4'(KDIM_MIN)) || (val[3:0] > 4'(KROW_MAX)) ||
               (val[7:4] < 4'(KDIM_MIN)) || (val[7:4] > 4'(KCOL_MAX));
      end
      OP_CLK_WR: begin
        done = 1'b1;
        bad  = (val[1:0] == 2'b01) || (val[1:0] == 2'b10);
      end
      OP_SCR_WR: begin
        if (idx == '0) begin
          bad  = sel_zero || addr_high;
          done = bad;
        end else begin
          done = (idx >= CNT_W'(2));
        end
      end
      OP_ENG_GO: begin
        done = 1'b1;
        bad  = sel_zero || addr_high;
      end
      OP_ENG_HALT: begin
        done = 1'b1;
        bad  = sel_zero;
      end
      OP_PARKED: bad = 1'b1;
      default: known = 1'b0;
    endcase
  end
endmodule

// File: rtl/kcb_rd_mux.sv
module kcb_rd_mux
  import kcb_pkg::*;
#(
  parameter int CNT_W  = 2,
  parameter int GPIO_W = 16
) (
  input  logic [7:0]        op,
  input  logic [CNT_W-1:0]  idx,
  input  logic [7:0]        stat,
  input  logic [7:0]        err,
  input  logic [7:0]        cfg,
  input  logic [7:0]        clkc,
  input  logic [7:0]        ksize,
  input  logic [GPIO_W-1:0] pdir,
  input  logic [GPIO_W-1:0] pmask,
  input  logic [7:0]        key_byte,
  output logic [7:0]        data,
  output logic              known
);
  logic [CNT_W+2:0] sh;
  assign sh = {idx, 3'b000};

  always_comb begin
    known = 1'b1;
    data  = 8'h00;
    unique case (op)
      OP_ID:       data = 8'(ID_WORD >> sh);
      OP_STAT_RD:  data = 8'(stat >> sh);
      OP_DIR_RD:   data = 8'(pdir >> sh);
      OP_MASK_RD:  data = 8'(pmask >> sh);
      OP_KEY_POP, OP_KEY_PEEK: data = key_byte;
      OP_ERR_RD:   data = err;
      OP_ROT_RD:   data = 8'h00;
      OP_SIZE_RD:  data = ksize;
      OP_CFG_RD:   data = {4'h0, cfg[3:0]};
      OP_CLK_RD:   data = {clkc[7:2], 2'b10};
      default:     known = 1'b0;
    endcase
  end
endmodule

// File: rtl/kpd_cmd_bank.sv
module kpd_cmd_bank
  import kcb_pkg::*;
#(
  parameter int GPIO_W     = 16,
  parameter int N_ENG      = 3,
  parameter int KDIM_MIN   = 3,
  parameter int KROW_MAX   = 12,
  parameter int KCOL_MAX   = 8,
  parameter int SCRIPT_MAX = 59
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_is_write,
  input  logic              wr_valid,
  input  logic [7:0]        wr_data,
  input  logic              rd_req,
  output logic [7:0]        rd_data,
  input  logic [7:0]        key_byte,
  output logic              key_clr,
  output logic              irq_n,
  output logic [7:0]        act_time,
  output logic [7:0]        debounce,
  output logic [7:0]        keypad_size,
  output logic [GPIO_W-1:0] gpio_pull,
  output logic [GPIO_W-1:0] gpio_dir,
  output logic [GPIO_W-1:0] gpio_mask,
  output logic              scr_wr,
  output logic [7:0]        scr_addr,
  output logic [15:0]       scr_word,
  output logic [N_ENG-1:0]  eng_go,
  output logic [N_ENG-1:0]  eng_halt,
  output logic [5:0]        eng_addr
);
  // counter only needs to reach the third parameter byte
  localparam int CNT_W = 2;
  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  logic [7:0]        cmd_q, cmd_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              wdir_q, wdir_n;
  logic [7:0]        cfg_q, cfg_n, stat_q, stat_n, err_q, err_n;
  logic [7:0]        act_q, act_n, deb_q, deb_n, size_q, size_n, clkc_q, clkc_n;
  logic [GPIO_W-1:0] pull_q, pull_n, pdir_q, pdir_n, pmask_q, pmask_n;
  logic [7:0]        saddr_q, saddr_n;
  logic [15:0]       sword_q, sword_n;
  logic [5:0]        eaddr_q, eaddr_n;
  logic              swr_q, swr_n, kclr_q, kclr_n;
  logic [N_ENG-1:0]  ego_q, ego_n, ehalt_q, ehalt_n;

  logic             acc_wr, acc_rd, reg_en;
  logic [CNT_W-1:0] pidx;
  logic             wk_known, wk_bad, wk_done, rk_known;
  logic [7:0]       errs;

  assign acc_wr = !xfer_start && wr_valid && wdir_q;
  assign acc_rd = !xfer_start && rd_req && !wdir_q;
  assign reg_en = xfer_start || acc_wr || acc_rd;
  assign pidx   = cnt_q - CNT_W'(1);

  kcb_wr_check #(
    .CNT_W(CNT_W), .KDIM_MIN(KDIM_MIN), .KROW_MAX(KROW_MAX),
    .KCOL_MAX(KCOL_MAX), .SCRIPT_MAX(SCRIPT_MAX)
  ) u_chk (
    .op(cmd_q), .idx(pidx), .val(wr_data),
    .known(wk_known), .bad(wk_bad), .done(wk_done)
  );

  kcb_rd_mux #(.CNT_W(CNT_W), .GPIO_W(GPIO_W)) u_rd (
    .op(cmd_q), .idx(cnt_q), .stat(stat_q), .err(err_q), .cfg(cfg_q),
    .clkc(clkc_q), .ksize(size_q), .pdir(pdir_q), .pmask(pmask_q),
    .key_byte(key_byte), .data(rd_data), .known(rk_known)
  );

  // next-state logic
  always_comb begin
    cmd_n = cmd_q;   cnt_n = cnt_q;   wdir_n = wdir_q;
    cfg_n = cfg_q;   stat_n = stat_q; err_n = err_q;
    act_n = act_q;   deb_n = deb_q;   size_n = size_q; clkc_n = clkc_q;
    pull_n = pull_q; pdir_n = pdir_q; pmask_n = pmask_q;
    saddr_n = saddr_q; sword_n = sword_q; eaddr_n = eaddr_q;
    swr_n = 1'b0; kclr_n = 1'b0; ego_n = '0; ehalt_n = '0;
    errs = 8'h00;

    if (xfer_start) begin
      cnt_n  = '0;
      wdir_n = xfer_is_write;
    end else if (acc_wr) begin
      cnt_n = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNT_W'(1);
      if (cnt_q == '0) begin
        cmd_n = wr_data;
      end else begin
        if (!wk_known) errs[ERRB_CMD] = 1'b1;
        if (wk_bad)    errs[ERRB_PARAM] = 1'b1;
        if (wk_done)   cmd_n = OP_PARKED;
        unique case (cmd_q)
          OP_CFG_WR: begin
            cfg_n  = wr_data;
            stat_n = 8'h00;
            kclr_n = 1'b1;
          end
          OP_SOFT_RST: if (!wk_bad) begin
            cfg_n = RST_CFG;   stat_n = RST_STAT; err_n = 8'h00;
            act_n = RST_ACT;   deb_n = RST_DEB;   size_n = RST_SIZE;
            clkc_n = RST_CLK;  pull_n = '0; pdir_n = '0; pmask_n = '0;
          end
          OP_PULL_WR: pull_n  = (pidx == '0) ? GPIO_W'(wr_data) : (pull_q  | GPIO_W'({wr_data, 8'h00}));
          OP_DIR_WR:  pdir_n  = (pidx == '0) ? GPIO_W'(wr_data) : (pdir_q  | GPIO_W'({wr_data, 8'h00}));
          OP_MASK_WR: pmask_n = (pidx == '0) ? GPIO_W'(wr_data) : (pmask_q | GPIO_W'({wr_data, 8'h00}));
          OP_ACT_WR:  act_n  = wr_data;
          OP_DEB_WR:  deb_n  = wr_data;
          OP_SIZE_WR: size_n = wr_data;
          OP_CLK_WR:  clkc_n = wr_data;
          OP_SCR_WR: begin
            if (pidx == '0) begin
              if (!wk_bad) begin
                saddr_n = wr_data;
                sword_n = 16'h0000;
              end
            end else if (pidx == CNT_W'(1)) begin
              sword_n[15:8] = wr_data;
            end else begin
              sword_n[7:0] = wr_data;
              swr_n = 1'b1;
            end
          end
          OP_ENG_GO: if (!wk_bad) begin
            eaddr_n = wr_data[7:2];
            for (int e = 0; e < N_ENG; e++)
              if (wr_data[1:0] == 2'(e + 1)) ego_n[e] = 1'b1;
          end
          OP_ENG_HALT: if (!wk_bad) begin
            for (int e = 0; e < N_ENG; e++)
              if (wr_data[1:0] == 2'(e + 1)) ehalt_n[e] = 1'b1;
          end
          default: ;
        endcase
      end
    end else if (acc_rd) begin
      cnt_n = (cnt_q == CNT_TOP) ? cnt_q : cnt_q + CNT_W'(1);
      if (!rk_known) errs[ERRB_CMD] = 1'b1;
      if (cmd_q == OP_STAT_RD && !stat_q[STB_NOINIT]) stat_n = 8'h00;
    end

    if (errs != 8'h00) begin
      err_n = err_n | errs;
      stat_n[STB_ERR] = 1'b1;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= OP_PARKED; cnt_q <= '0; wdir_q <= 1'b0;
      cfg_q <= RST_CFG;   stat_q <= RST_STAT; err_q <= 8'h00;
      act_q <= RST_ACT;   deb_q <= RST_DEB;   size_q <= RST_SIZE; clkc_q <= RST_CLK;
      pull_q <= '0; pdir_q <= '0; pmask_q <= '0;
      saddr_q <= 8'h00; sword_q <= 16'h0000; eaddr_q <= 6'd0;
    end else if (reg_en) begin
      cmd_q <= cmd_n; cnt_q <= cnt_n; wdir_q <= wdir_n;
      cfg_q <= cfg_n; stat_q <= stat_n; err_q <= err_n;
      act_q <= act_n; deb_q <= deb_n; size_q <= size_n; clkc_q <= clkc_n;
      pull_q <= pull_n; pdir_q <= pdir_n; pmask_q <= pmask_n;
      saddr_q <= saddr_n; sword_q <= sword_n; eaddr_q <= eaddr_n;
    end
  end

  // single-cycle strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swr_q <= 1'b0; kclr_q <= 1'b0; ego_q <= '0; ehalt_q <= '0;
    end else begin
      swr_q <= swr_n; kclr_q <= kclr_n; ego_q <= ego_n; ehalt_q <= ehalt_n;
    end
  end

  assign irq_n       = (stat_q == 8'h00);
  assign key_clr     = kclr_q;
  assign act_time    = act_q;
  assign debounce    = deb_q;
  assign keypad_size = size_q;
  assign gpio_pull   = pull_q;
  assign gpio_dir    = pdir_q;
  assign gpio_mask   = pmask_q;
  assign scr_wr      = swr_q;
  assign scr_addr    = saddr_q;
  assign scr_word    = sword_q;
  assign eng_go      = ego_q;
  assign eng_halt    = ehalt_q;
  assign eng_addr    = eaddr_q;

  // R3: a freshly raised error bit always comes with the status error flag
  p_err_flags_status_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ((err_q & ~$past(err_q)) != 8'h00)) |-> stat_q[STB_ERR]);

  // R3: a single-parameter command parks once its parameter is taken
  p_park_after_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_wr && cnt_q != '0 && cmd_q == OP_SIZE_WR) |=> (cmd_q == OP_PARKED));

  // R8: a status read releases the interrupt unless not-initialised is set
  p_stat_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && cmd_q == OP_STAT_RD && !stat_q[STB_NOINIT]) |=> irq_n);

  // R8: the not-initialised flag survives a status read
  p_noinit_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_rd && cmd_q == OP_STAT_RD && stat_q[STB_NOINIT]) |=> (stat_q[STB_NOINIT] && !irq_n));

  // R2: a transaction start zeroes the byte counter
  p_start_clears_cnt_r2: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> (cnt_q == '0));

  // R12: at most one engine strobed at a time
  p_eng_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ego_q) && $onehot0(ehalt_q));
endmodule

// File: tb/tb_kpd_cmd_bank.sv
module tb_kpd_cmd_bank;
  localparam logic [1:0] K_CMD = 2'd0;  // start write + opcode
  localparam logic [1:0] K_PRM = 2'd1;  // parameter byte
  localparam logic [1:0] K_GET = 2'd2;  // start read + first byte, checked
  localparam logic [1:0] K_NXT = 2'd3;  // next read byte, checked
  localparam int NV = 64;

  // {requirement, kind, data, expected}
  localparam logic [21:0] VEC [NV] = '{
    // R9 config write clears status, low nibble read back
    {4'd9, K_CMD, 8'h81, 8'h00}, {4'd9, K_PRM, 8'h05, 8'h00},
    {4'd9, K_CMD, 8'h92, 8'h00}, {4'd9, K_GET, 8'h00, 8'h05},
    {4'd9, K_CMD, 8'h82, 8'h00}, {4'd9, K_GET, 8'h00, 8'h00},
    // R2 id bytes, low first
    {4'd2, K_CMD, 8'h80, 8'h00}, {4'd2, K_GET, 8'h00, 8'h00},
    {4'd2, K_NXT, 8'h00, 8'h04}, {4'd2, K_NXT, 8'h00, 8'h00},
    // R7 16-bit port words
    {4'd7, K_CMD, 8'h85, 8'h00}, {4'd7, K_PRM, 8'h34, 8'h00},
    {4'd7, K_PRM, 8'h12, 8'h00}, {4'd7, K_CMD, 8'h87, 8'h00},
    {4'd7, K_GET, 8'h00, 8'h34}, {4'd7, K_NXT, 8'h00, 8'h12},
    {4'd7, K_CMD, 8'h86, 8'h00}, {4'd7, K_PRM, 8'hCD, 8'h00},
    {4'd7, K_PRM, 8'hAB, 8'h00}, {4'd7, K_CMD, 8'h88, 8'h00},
    {4'd7, K_GET, 8'h00, 8'hCD}, {4'd7, K_NXT, 8'h00, 8'hAB},
    // R4 keypad size, edge-valid then out of range
    {4'd4, K_CMD, 8'h90, 8'h00}, {4'd4, K_PRM, 8'h4C, 8'h00},
    {4'd4, K_CMD, 8'h8C, 8'h00}, {4'd4, K_GET, 8'h00, 8'h00},
    {4'd4, K_CMD, 8'h90, 8'h00}, {4'd4, K_PRM, 8'h92, 8'h00},
    {4'd4, K_CMD, 8'h91, 8'h00}, {4'd4, K_GET, 8'h00, 8'h92},
    {4'd4, K_CMD, 8'h8C, 8'h00}, {4'd4, K_GET, 8'h00, 8'h01},
    // R3 error raised status bit 3
    {4'd3, K_CMD, 8'h82, 8'h00}, {4'd3, K_GET, 8'h00, 8'h08},
    // R5 clock check and read format
    {4'd5, K_CMD, 8'h93, 8'h00}, {4'd5, K_PRM, 8'hF1, 8'h00},
    {4'd5, K_CMD, 8'h94, 8'h00}, {4'd5, K_GET, 8'h00, 8'hF2},
    {4'd5, K_CMD, 8'h82, 8'h00}, {4'd5, K_GET, 8'h00, 8'h08},
    {4'd5, K_CMD, 8'h93, 8'h00}, {4'd5, K_PRM, 8'hF3, 8'h00},
    {4'd5, K_CMD, 8'h82, 8'h00}, {4'd5, K_GET, 8'h00, 8'h00},
    // R3 extra byte after a completed command
    {4'd3, K_CMD, 8'h8B, 8'h00}, {4'd3, K_PRM, 8'h10, 8'h00},
    {4'd3, K_PRM, 8'h11, 8'h00}, {4'd3, K_CMD, 8'h82, 8'h00},
    {4'd3, K_GET, 8'h00, 8'h08},
    // R10 unknown opcode read
    {4'd10, K_CMD, 8'h8D, 8'h00}, {4'd10, K_GET, 8'h00, 8'h00},
    {4'd10, K_CMD, 8'h8C, 8'h00}, {4'd10, K_GET, 8'h00, 8'h03},
    // R6 soft reset, wrong key then right key
    {4'd6, K_CMD, 8'h83, 8'h00}, {4'd6, K_PRM, 8'h55, 8'h00},
    {4'd6, K_CMD, 8'h82, 8'h00}, {4'd6, K_GET, 8'h00, 8'h08},
    {4'd6, K_CMD, 8'h83, 8'h00}, {4'd6, K_PRM, 8'hAA, 8'h00},
    {4'd6, K_CMD, 8'h82, 8'h00}, {4'd6, K_GET, 8'h00, 8'h10},
    {4'd6, K_NXT, 8'h00, 8'h00}, {4'd6, K_CMD, 8'h8C, 8'h00},
    {4'd6, K_GET, 8'h00, 8'h00}
  };

  logic        clk, rst_n;
  logic        xfer_start, xfer_is_write, wr_valid, rd_req;
  logic [7:0]  wr_data, rd_data, key_byte;
  logic        key_clr, irq_n, scr_wr;
  logic [7:0]  act_time, debounce, keypad_size, scr_addr;
  logic [15:0] gpio_pull, gpio_dir, gpio_mask, scr_word;
  logic [2:0]  eng_go, eng_halt;
  logic [5:0]  eng_addr;
  int nchk, nfail;
  logic [7:0] got;

  kpd_cmd_bank dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_is_write(xfer_is_write),
    .wr_valid(wr_valid), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
    .key_byte(key_byte), .key_clr(key_clr), .irq_n(irq_n), .act_time(act_time),
    .debounce(debounce), .keypad_size(keypad_size), .gpio_pull(gpio_pull),
    .gpio_dir(gpio_dir), .gpio_mask(gpio_mask), .scr_wr(scr_wr), .scr_addr(scr_addr),
    .scr_word(scr_word), .eng_go(eng_go), .eng_halt(eng_halt), .eng_addr(eng_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic start(input logic w);
    @(negedge clk);
    xfer_start = 1'b1; xfer_is_write = w;
    @(posedge clk); #1;
    xfer_start = 1'b0;
  endtask

  task automatic wbyte(input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    @(posedge clk); #1;
    wr_valid = 1'b0;
  endtask

  task automatic rbyte(output logic [7:0] r);
    @(negedge clk);
    rd_req = 1'b1;
    #1 r = rd_data;
    @(posedge clk); #1;
    rd_req = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] op);
    start(1'b1);
    wbyte(op);
  endtask

  task automatic get(input logic [7:0] op, input string tag, input logic [7:0] exp);
    cmd(op);
    start(1'b0);
    rbyte(got);
    chk(tag, got, exp);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    nchk = 0; nfail = 0;
    rst_n = 1'b0; xfer_start = 1'b0; xfer_is_write = 1'b0;
    wr_valid = 1'b0; wr_data = 8'h00; rd_req = 1'b0; key_byte = 8'h5A;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    chk("R1 irq_n", {7'b0, irq_n}, 8'h00);
    chk("R1 debounce", debounce, 8'd3);
    chk("R1 act_time", act_time, 8'd125);
    get(8'h91, "R1 size", 8'h33);
    get(8'h94, "R1 clock", 8'h0A);
    get(8'h92, "R1 config", 8'h00);
    get(8'h82, "R1 status", 8'h10);
    get(8'h82, "R8 noinit sticky", 8'h10);

    // table walk
    for (int i = 0; i < NV; i++) begin
      logic [3:0] rq;
      logic [1:0] kd;
      logic [7:0] dv, ev;
      {rq, kd, dv, ev} = VEC[i];
      case (kd)
        K_CMD: cmd(dv);
        K_PRM: wbyte(dv);
        K_GET: begin start(1'b0); rbyte(got); chk($sformatf("R%0d vec %0d", rq, i), got, ev); end
        default: begin rbyte(got); chk($sformatf("R%0d vec %0d", rq, i), got, ev); end
      endcase
    end

    // R9 key queue clear pulse and irq release (R8)
    cmd(8'h81); wbyte(8'h00);
    chk("R9 key_clr", {7'b0, key_clr}, 8'h01);
    chk("R8 irq released", {7'b0, irq_n}, 8'h01);
    get(8'h87, "R6 port word cleared", 8'h00);

    // R5 debounce zero stored but flagged
    cmd(8'h8F); wbyte(8'h00);
    chk("R5 debounce stored", debounce, 8'h00);
    chk("R8 irq on error", {7'b0, irq_n}, 8'h00);
    get(8'h82, "R5 status", 8'h08);
    chk("R8 irq after read", {7'b0, irq_n}, 8'h01);

    // R10 unknown opcode write
    cmd(8'h8D); wbyte(8'h01);
    get(8'h8C, "R10 error reg", 8'h03);
    get(8'h82, "R10 status", 8'h08);

    // R11 script write
    cmd(8'h95); wbyte(8'h0D); wbyte(8'hAB); wbyte(8'h12);
    chk("R11 scr_wr", {7'b0, scr_wr}, 8'h01);
    chk("R11 scr_addr", scr_addr, 8'h0D);
    chk("R11 word hi", scr_word[15:8], 8'hAB);
    chk("R11 word lo", scr_word[7:0], 8'h12);
    get(8'h82, "R11 status clean", 8'h00);
    cmd(8'h95); wbyte(8'hF1); wbyte(8'h00);
    chk("R11 no strobe", {7'b0, scr_wr}, 8'h00);
    chk("R11 addr kept", scr_addr, 8'h0D);
    get(8'h82, "R11 bad addr", 8'h08);

    // R12 engines
    cmd(8'h96); wbyte(8'h0E);
    chk("R12 go", {5'b0, eng_go}, 8'h02);
    chk("R12 addr", {2'b0, eng_addr}, 8'h03);
    cmd(8'h97); wbyte(8'h03);
    chk("R12 halt", {5'b0, eng_halt}, 8'h04);
    cmd(8'h97); wbyte(8'h00);
    chk("R12 halt none", {5'b0, eng_halt}, 8'h00);
    get(8'h82, "R12 bad select", 8'h08);

    // R2 a new start rewinds the counter
    get(8'h80, "R2 id lo", 8'h00);
    rbyte(got); chk("R2 id hi", got, 8'h04);
    start(1'b0); rbyte(got); chk("R2 restart", got, 8'h00);

    summary();
  end
endmodule